// File: doc/BRIEF.md
# Bipolar Mark-Inversion Encoder with Violation Injector

This block turns a serial NRZ bit stream into three-level bipolar symbols carried on two rails. A one becomes a mark on either the positive or the negative rail, and successive marks alternate polarity. A zero leaves both rails low. Each input bit is qualified by a valid strobe. A bit presented with valid high appears on the rails one clock later. A cycle with valid low produces a quiet symbol and does not advance the encoder.

For line testing, the block can send one deliberate bipolar violation. A violation is a mark with the same polarity as the mark before it. A one-cycle request arms the injector. The injector then waits for the next eligible one. A one is not eligible when the bits just before it are zeros; those ones are sent normally and the injector keeps waiting. When the violation goes out, a done pulse marks that same symbol. The controller can use this pulse to clear the command bit that raised the request. After a violation, alternation resumes from the polarity of the violation mark.

Top module: `ami_viol_enc`

## Requirements
- R1: A cycle with data_vld low, or with data_vld high and data_in 0, gives pos=0 and neg=0 one clock later.
- R2: A valid one that is not turned into a violation gives a mark one clock later, and its polarity is opposite to the previous mark. pos=1 means a positive mark and neg=1 means a negative mark, and the two are never high together. The first mark after reset is positive.
- R3: After a request arms the injector, the next eligible valid one is sent as a violation, with the same polarity as the previous mark. Only one violation is sent for each request.
- R4: A valid one is not eligible when the GUARD_ZEROS (default 2) valid bits just before it are all zero. Bit history counts as zeros after reset. Such a one is sent as a normal mark and the injector stays armed. With a request at the first bit, the input 001000010100 produces its violation only on the final one.
- R5: The first normal mark after a violation has the polarity opposite to the violation mark.
- R6: inj_done is high for exactly the cycle in which the violation symbol is on the rails. It is low in every other cycle.
- R7: A request that arrives while the injector is armed is ignored. This includes the cycle in which the armed violation is sent, so no second violation follows.
- R8: A request sampled in the same cycle as an eligible valid one applies to that one.
- R9: While rst is high, and in the cycle after it is sampled, pos, neg and inj_done are 0 and the injector is disarmed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| data_in | input | 1 | NRZ data bit |
| data_vld | input | 1 | Qualifies data_in for this cycle |
| inj_req | input | 1 | One-cycle request to insert a violation |
| pos | output | 1 | Positive mark rail (registered) |
| neg | output | 1 | Negative mark rail (registered) |
| inj_done | output | 1 | Pulse marking the violation symbol (registered) |

## Verification
Two functions can fall in the same cycle. The first is a fresh request arriving together with an eligible one, whether the injector is idle or already armed. The second is a request landing exactly when the armed violation fires. The stimulus places requests directly on eligible ones, on ineligible ones after zero runs, and on idle cycles. It also places them one and two bits before the firing point. A behavioural model, built on a zero-run counter and a signed polarity, gives the rails and the done pulse for each cycle. The model judges whether a request took effect on that one or was dropped. It also checks that the following mark resumes alternation.

// File: rtl/ami_enc_pkg.sv
package ami_enc_pkg;
  typedef enum logic [1:0] {
    SYM_ZERO = 2'b00,
    SYM_POS  = 2'b01,
    SYM_NEG  = 2'b10
  } sym_t;
endpackage

// File: rtl/ami_zero_guard.sv
// Remembers the last GUARD_ZEROS valid bits and reports whether any was a one.
module ami_zero_guard #(
  parameter int GUARD_ZEROS = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic bit_vld,
  input  logic bit_val,
  output logic recent_one
);
  localparam int HW = (GUARD_ZEROS < 1) ? 1 : GUARD_ZEROS;

  logic [HW-1:0] hist_q;

  generate
    if (HW == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst)          hist_q <= '0;
        else if (bit_vld) hist_q <= bit_val;
      end
    end else begin : g_shift
      always_ff @(posedge clk) begin
        if (rst)          hist_q <= '0;
        else if (bit_vld) hist_q <= {hist_q[HW-2:0], bit_val};
      end
    end
  endgenerate

  assign recent_one = |hist_q;
endmodule

// File: rtl/ami_inject_arm.sv
// Holds a pending violation request until an eligible one consumes it.
module ami_inject_arm (
  input  logic clk,
  input  logic rst,
  input  logic req,
  input  logic elig_one,
  output logic fire
);
  logic armed_q;

  assign fire = elig_one & (armed_q | req);

  always_ff @(posedge clk) begin
    if (rst)       armed_q <= 1'b0;
    else if (fire) armed_q <= 1'b0;
    else if (req)  armed_q <= 1'b1;
  end
endmodule

// File: rtl/ami_mark_pol.sv
// Tracks the polarity of the last mark and picks the symbol for this bit.
module ami_mark_pol
  import ami_enc_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic mark,
  input  logic viol,
  output sym_t sym
);
  logic last_pos_q;
  logic next_pos;

  assign next_pos = viol ? last_pos_q : ~last_pos_q;

  always_comb begin
    if (!mark)        sym = SYM_ZERO;
    else if (next_pos) sym = SYM_POS;
    else              sym = SYM_NEG;
  end

  always_ff @(posedge clk) begin
    if (rst)       last_pos_q <= 1'b0;
    else if (mark) last_pos_q <= next_pos;
  end
endmodule

// File: rtl/ami_viol_enc.sv
module ami_viol_enc
  import ami_enc_pkg::*;
#(
  parameter int GUARD_ZEROS = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic data_in,
  input  logic data_vld,
  input  logic inj_req,
  output logic pos,
  output logic neg,
  output logic inj_done
);
  logic one_now;
  logic recent_one;
  logic elig_one;
  logic fire;
  sym_t sym;

  assign one_now  = data_vld & data_in;
  assign elig_one = one_now & recent_one;

  ami_zero_guard #(.GUARD_ZEROS(GUARD_ZEROS)) u_guard (
    .clk        (clk),
    .rst        (rst),
    .bit_vld    (data_vld),
    .bit_val    (data_in),
    .recent_one (recent_one)
  );

  ami_inject_arm u_arm (
    .clk      (clk),
    .rst      (rst),
    .req      (inj_req),
    .elig_one (elig_one),
    .fire     (fire)
  );

  ami_mark_pol u_pol (
    .clk  (clk),
    .rst  (rst),
    .mark (one_now),
    .viol (fire),
    .sym  (sym)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pos      <= 1'b0;
      neg      <= 1'b0;
      inj_done <= 1'b0;
    end else begin
      pos      <= (sym == SYM_POS);
      neg      <= (sym == SYM_NEG);
      inj_done <= fire;
    end
  end
endmodule

// File: rtl/ami_viol_enc_chk.sv
module ami_viol_enc_chk #(
  parameter int GUARD_ZEROS = 2
) (
  input logic clk,
  input logic rst,
  input logic data_in,
  input logic data_vld,
  input logic inj_req,
  input logic pos,
  input logic neg,
  input logic inj_done
);
  localparam int HW = (GUARD_ZEROS < 1) ? 1 : GUARD_ZEROS;

  logic [HW-1:0] ck_hist;
  logic          seen_mark;
  logic          last_out_pos;

  always_ff @(posedge clk) begin
    if (rst) begin
      ck_hist      <= '0;
      seen_mark    <= 1'b0;
      last_out_pos <= 1'b0;
    end else begin
      if (data_vld) ck_hist <= (HW == 1) ? HW'(data_in) : HW'({ck_hist, data_in});
      if (pos || neg) begin
        seen_mark    <= 1'b1;
        last_out_pos <= pos;
      end
    end
  end

  AST_RAILS_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(pos && neg)); // R2

  AST_QUIET_ON_ZERO: assert property (@(posedge clk) disable iff (rst)
    !(data_vld && data_in) |=> (!pos && !neg)); // R1

  AST_NORMAL_ALT: assert property (@(posedge clk) disable iff (rst)
    ((pos || neg) && !inj_done && seen_mark) |-> (pos != last_out_pos)); // R2

  AST_VIOL_SAME: assert property (@(posedge clk) disable iff (rst)
    inj_done |-> (seen_mark && (pos || neg) && (pos == last_out_pos))); // R3

  AST_INELIG_SKIP: assert property (@(posedge clk) disable iff (rst)
    (data_vld && data_in && (ck_hist == '0)) |=> !inj_done); // R4

  AST_SAME_CYCLE_REQ: assert property (@(posedge clk) disable iff (rst)
    (data_vld && data_in && (ck_hist != '0) && inj_req) |=> inj_done); // R8
endmodule

bind ami_viol_enc ami_viol_enc_chk #(.GUARD_ZEROS(GUARD_ZEROS)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .data_in  (data_in),
  .data_vld (data_vld),
  .inj_req  (inj_req),
  .pos      (pos),
  .neg      (neg),
  .inj_done (inj_done)
);

// File: tb/ami_viol_enc_tb.sv
`timescale 1ns/1ps
module ami_viol_enc_tb;
  localparam int GZ = 2;

  logic clk = 1'b0;
  logic rst, data_in, data_vld, inj_req;
  logic pos, neg, inj_done;

  int total = 0;
  int bad   = 0;
  bit done_flag = 0;

  // reference model state
  int    zrun;
  int    lastpol;
  bit    armed;
  bit    after_viol;
  bit    e_pos, e_neg, e_done;
  string e_tag;

  always #10 clk = ~clk;

  ami_viol_enc #(.GUARD_ZEROS(GZ)) u_dut (
    .clk(clk), .rst(rst), .data_in(data_in), .data_vld(data_vld),
    .inj_req(inj_req), .pos(pos), .neg(neg), .inj_done(inj_done)
  );

  task automatic model_step(input bit r, input bit v, input bit d, input bit q);
    bit one, elig, fire;
    int pol;
    if (r) begin
      zrun = GZ; lastpol = -1; armed = 0; after_viol = 0;
      e_pos = 0; e_neg = 0; e_done = 0; e_tag = "R9";
      return;
    end
    one  = v && d;
    elig = one && (zrun < GZ);
    fire = elig && (armed || q);
    e_done = fire;
    e_pos = 0; e_neg = 0;
    if (!one) e_tag = "R1";
    else if (fire) e_tag = armed ? "R3" : "R8";
    else if (after_viol) e_tag = "R5";
    else if (armed && !elig) e_tag = "R4";
    else e_tag = "R2";
    if (q && armed) e_tag = "R7";
    if (one) begin
      pol = fire ? lastpol : -lastpol;
      lastpol = pol;
      e_pos = (pol > 0);
      e_neg = (pol < 0);
      after_viol = fire;
    end
    if (fire) armed = 0;
    else if (q) armed = 1;
    if (v) zrun = one ? 0 : ((zrun < GZ) ? zrun + 1 : GZ);
  endtask

  task automatic cyc(input bit r, input bit v, input bit d, input bit q);
    @(negedge clk);
    if (!done_flag) begin
      total++;
      if (pos !== e_pos || neg !== e_neg) begin
        bad++;
        $display("FAIL %s rails: got pos=%0b neg=%0b exp pos=%0b neg=%0b at %0t",
                 e_tag, pos, neg, e_pos, e_neg, $time);
      end
      total++;
      if (inj_done !== e_done) begin
        bad++;
        $display("FAIL %s inj_done: got %0b exp %0b at %0t",
                 (e_done ? "R6" : e_tag), inj_done, e_done, $time);
      end
    end
    model_step(r, v, d, q);
    rst = r; data_vld = v; data_in = d; inj_req = q;
  endtask

  initial begin
    #1000000;
    if (!done_flag) begin
      done_flag = 1;
      total++; bad++;
      $display("FAIL watchdog expired: got hang exp completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [11:0] pat;
    logic [15:0] lfsr;
    rst = 1; data_vld = 0; data_in = 0; inj_req = 0;
    model_step(1, 0, 0, 0);
    for (int i = 0; i < 3; i++) cyc(1, 0, 0, 0);
    // R9 reset state observed in the first post-reset compare
    // R4 example: request at first bit; only the final eligible one is violated
    pat = 12'b001000010100;
    for (int i = 11; i >= 0; i--) cyc(0, 1, pat[i], i == 11);
    cyc(0, 1, 1, 0); cyc(0, 1, 1, 0);
    // R8 request on an eligible one; then R7 request while armed
    cyc(0, 1, 1, 1); cyc(0, 1, 0, 0); cyc(0, 1, 1, 0);
    cyc(0, 1, 0, 1); cyc(0, 1, 0, 1); cyc(0, 1, 0, 0); cyc(0, 1, 1, 0);
    cyc(0, 1, 0, 0); cyc(0, 1, 1, 1); cyc(0, 1, 1, 0); cyc(0, 1, 1, 0);
    // R1 idle cycles do not advance history
    cyc(0, 1, 1, 0); cyc(0, 0, 1, 1); cyc(0, 0, 0, 0); cyc(0, 1, 1, 0);
    cyc(0, 1, 1, 0);
    // mid-stream reset
    cyc(1, 1, 1, 1); cyc(0, 1, 1, 1); cyc(0, 1, 1, 0); cyc(0, 1, 1, 0);
    // pseudo-random stream with requests and idle gaps
    lfsr = 16'hACE1;
    for (int i = 0; i < 3000; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      cyc(0, lfsr[3:0] != 4'h0, lfsr[5] | lfsr[7], lfsr[11:8] == 4'h5);
    end
    cyc(0, 0, 0, 0); cyc(0, 0, 0, 0);
    if (!done_flag) begin
      done_flag = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule